// File: doc/BRIEF.md
# FIFO-fed pulse-width modulator

This block produces one pulse-width modulated output from a free-running prescaled up-counter and a stream of duty values queued in a small sample FIFO. Software programs it through a six-register bank on a simple single-cycle bus. The bank holds a control word, write-one-to-clear event flags, interrupt enables, the sample port, the wrap point and the live count. A programmable divider slows the input clock. The counter climbs from zero to the wrap point and starts again. Each queued duty value stays in force for one, two, four or eight whole periods before the next entry is taken.

The pulse can be active-high or active-low. Compare, roll-over and FIFO-empty conditions each drive the single interrupt line through their own enable bit. A self-clearing software reset flushes the queue, the counting state and the event flags, and leaves the rest of the configuration as written.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After the reset input is released, the status register reads 0x08 (queue empty, level 0), the counter and sample registers read 0, the output is low and the interrupt line is low.
- R2: Register indices are 0 control, 1 status, 2 interrupt enable, 3 sample, 4 period and 5 counter. Control reads back enable at bit 0, repeat select at bits 2:1, software reset at bit 3, divider at bits 15:4 and polarity at bits 19:18. Enables read back at bits 2:0 and the period at bits 15:0. Unused indices read 0.
- R3: While enabled, the counter advances once every N+1 clock cycles, where N is the divider field. When the generator is disabled, the divider state and the counter return to 0.
- R4: On a counting step, the counter moves from its current value to value+1. If the current value is at or above the period register, it moves to 0 instead, which is a roll-over. The counter register returns the live count.
- R5: A write to the sample register pushes bits 15:0 into a 4-entry FIFO if fewer than 4 entries were held at that clock. Otherwise the value is dropped and status bit 6 is set. Status bits 2:0 give the number of held entries, and bit 3 is 1 while none are held.
- R6: The first enabled cycle with no active sample takes the FIFO head. After that, a new head is taken at the roll-over that ends a window of 1, 2, 4 or 8 periods, selected by control bits 2:1 = 0, 1, 2 or 3. With an empty FIFO the active sample is kept. The sample register reads the active sample.
- R7: The pulse is active while the counter is below the active sample, or for the whole period if the sample is at least the period value. A sample of 0 is never active. With the generator disabled or no sample taken yet, the output rests at its inactive level.
- R8: Polarity field value 1 inverts the output, including its resting level. Values 0, 2 and 3 give an active-high pulse.
- R9: Status bit 5 is set on a counting step whose new count equals the active sample, once a sample is present. Status bit 4 is set on every roll-over.
- R10: Writing 1 to status bit 6, 5 or 4 clears that flag, and writing 0 leaves it unchanged. If an event sets a flag in the same cycle as a clearing write, the flag stays set.
- R11: The interrupt is (status5 AND enable2) OR (status4 AND enable1) OR (status3 AND enable0).
- R12: Writing control with bit 3 set makes the next clock empty the FIFO and clear the counter, divider, repeat count, active sample and all event flags. Bit 3 then reads 0, and the other control fields keep their written values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output |
| irq | output | 1 | Interrupt request |

## Verification
A register write takes effect at the rising edge that samples it, and the result can be read back in the following cycle. The output, interrupt and read data are combinational from the register state, so each of them shows the effect of a counting step, fetch or flag update in the cycle that follows the edge that caused it. The software reset is the exception: it needs two edges, one to latch the request and one to apply it. The bench runs a behavioural model on the same rising edge as the design and compares the output, interrupt line and read data of the addressed register at every falling edge. This keeps each result aligned to the cycle in which it is due. Directed reads of status, control and counter at fixed points add exact expected values for the queue overflow, the software reset and the disable behaviour.

// File: rtl/pwmfg_pkg.sv
package pwmfg_pkg;

   typedef enum logic [2:0] {
      REG_CTRL = 3'd0,
      REG_STAT = 3'd1,
      REG_IEN  = 3'd2,
      REG_SAMP = 3'd3,
      REG_PER  = 3'd4,
      REG_CNT  = 3'd5
   } reg_sel_e;

   // control field positions
   localparam int C_EN     = 0;
   localparam int C_REP_LO = 1;
   localparam int C_SWR    = 3;
   localparam int C_DIV_LO = 4;
   localparam int C_POL_LO = 18;

   // status field positions
   localparam int S_FWE   = 6;
   localparam int S_CMP   = 5;
   localparam int S_ROV   = 4;
   localparam int S_EMPTY = 3;

   // interrupt enable positions
   localparam int I_CMP   = 2;
   localparam int I_ROV   = 1;
   localparam int I_EMPTY = 0;

   localparam logic [1:0] POL_ACTIVE_LOW = 2'b01;

endpackage

// File: rtl/pwmfg_prescale.sv
module pwmfg_prescale #(
   parameter int DIV_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] pre_q;

   assign tick = run && (pre_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pre_q <= '0;
      else if (!run || tick)
         pre_q <= '0;
      else
         pre_q <= pre_q + 1'b1;
   end

   // R3: a step is followed by a gap unless the divide ratio is one
   a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> (!tick || div == '0));

   a_r3_idle_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> pre_q == '0);

endmodule

// File: rtl/pwmfg_fifo.sv
module pwmfg_fifo #(
   parameter int WIDTH = 16,
   parameter int DEPTH = 4,
   localparam int LVL_W = $clog2(DEPTH + 1),
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic             pop,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_p, wr_p, rd_n, wr_n;
   logic             push_ok, pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full && !clr;
   assign pop_ok  = pop && !empty && !clr;
   assign dout    = mem[rd_p];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign rd_n = rd_p + 1'b1;
         assign wr_n = wr_p + 1'b1;
      end else begin : g_wrap
         assign rd_n = (rd_p == PTR_W'(DEPTH - 1)) ? '0 : rd_p + 1'b1;
         assign wr_n = (wr_p == PTR_W'(DEPTH - 1)) ? '0 : wr_p + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_p  <= '0;
         wr_p  <= '0;
         level <= '0;
      end else if (clr) begin
         rd_p  <= '0;
         wr_p  <= '0;
         level <= '0;
      end else begin
         if (push_ok) wr_p <= wr_n;
         if (pop_ok)  rd_p <= rd_n;
         level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_p] <= din;
   end

   // R5: occupancy never passes the depth, a push into a full queue is dropped
   a_r5_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   a_r5_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> full);

   a_r12_flush: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

endmodule

// File: rtl/pwmfg_counter.sv
module pwmfg_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             tick,
   input  logic [CNT_W-1:0] period,
   input  logic [1:0]       rep_sel,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic             wrap,
   output logic             win_end
);

   logic [2:0] rep_q;
   logic [2:0] reps_m1;

   always_comb begin
      case (rep_sel)
         2'd0:    reps_m1 = 3'd0;
         2'd1:    reps_m1 = 3'd1;
         2'd2:    reps_m1 = 3'd3;
         default: reps_m1 = 3'd7;
      endcase
   end

   assign wrap    = tick && (cnt >= period);
   assign cnt_nxt = wrap ? '0 : cnt + 1'b1;
   assign win_end = wrap && (rep_q >= reps_m1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         rep_q <= '0;
      end else if (!run) begin
         cnt   <= '0;
         rep_q <= '0;
      end else begin
         if (tick) cnt <= cnt_nxt;
         if (wrap) rep_q <= win_end ? 3'd0 : rep_q + 3'd1;
      end
   end

   // R4: roll-over lands on zero, a plain step adds one
   a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> cnt == '0);

   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap) |=> cnt == $past(cnt) + 1'b1);

   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !tick) |=> $stable(cnt));

endmodule

// File: rtl/pwmfg_wave.sv
module pwmfg_wave #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic             tick,
   input  logic             avail,
   input  logic [CNT_W-1:0] head,
   input  logic             win_end,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [CNT_W-1:0] period,
   input  logic             pol_low,
   output logic             pop,
   output logic [CNT_W-1:0] cur,
   output logic             cmp_ev,
   output logic             pwm_out
);

   logic valid_q;
   logic act;

   assign pop    = run && avail && (!valid_q || win_end);
   assign cmp_ev = tick && valid_q && (cnt_nxt == cur);
   assign act    = run && valid_q && (cur != '0) &&
                   ((cnt < cur) || (cur >= period));
   assign pwm_out = act ^ pol_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur     <= '0;
         valid_q <= 1'b0;
      end else if (clr) begin
         cur     <= '0;
         valid_q <= 1'b0;
      end else if (pop) begin
         cur     <= head;
         valid_q <= 1'b1;
      end
   end

   // R7: a zero sample never drives the active level
   a_r7_zero_sample: assert property (@(posedge clk) disable iff (!rst_n)
      (cur == '0) |-> (pwm_out == pol_low));

   // R8: a stopped generator rests at the inactive level of the chosen polarity
   a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> (pwm_out == pol_low));

   // R6: a fetch makes a sample active on the next cycle
   a_r6_fetch_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !clr) |=> valid_q);

endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
   import pwmfg_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int ADDR_W     = 3,
   parameter int CNT_W      = 16,
   parameter int DIV_W      = 12,
   parameter int FIFO_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              pwm_out,
   output logic              irq
);

   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (DATA_W < 20) begin : g_bad_data
         $error("DATA_W must hold the polarity field");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ADDR_W must index six registers");
      end
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
         $error("CNT_W must lie in 2..16");
      end
      if (DIV_W < 1 || DIV_W > 12) begin : g_bad_div
         $error("DIV_W must lie in 1..12");
      end
      if (FIFO_DEPTH < 2 || LVL_W > 3) begin : g_bad_depth
         $error("FIFO_DEPTH must lie in 2..7");
      end
   endgenerate

   // configuration state
   logic             en_q, swr_q;
   logic [1:0]       rep_q, pol_q;
   logic [DIV_W-1:0] div_q;
   logic [2:0]       ie_q;
   logic [CNT_W-1:0] per_q;
   logic             fwe_q, cmp_q, rov_q;

   // decoded bus accesses
   logic wr_ctrl, wr_stat, wr_ien, wr_samp, wr_per;
   logic unused_wdata;

   assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));
   assign wr_stat = bus_wr && (bus_addr == ADDR_W'(REG_STAT));
   assign wr_ien  = bus_wr && (bus_addr == ADDR_W'(REG_IEN));
   assign wr_samp = bus_wr && (bus_addr == ADDR_W'(REG_SAMP));
   assign wr_per  = bus_wr && (bus_addr == ADDR_W'(REG_PER));
   assign unused_wdata = ^bus_wdata;

   // datapath wiring
   logic             run, tick, wrap, win_end, pop, cmp_ev, pol_low;
   logic             push_req, fifo_full, fifo_empty, fwe_set;
   logic [CNT_W-1:0] cnt_q, cnt_nxt, head, cur;
   logic [LVL_W-1:0] fifo_level;

   assign run      = en_q && !swr_q;
   assign push_req = wr_samp && !swr_q;
   assign fwe_set  = push_req && fifo_full;
   assign pol_low  = (pol_q == POL_ACTIVE_LOW);

   pwmfg_prescale #(.DIV_W(DIV_W)) u_pre (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (div_q),
      .tick (tick)
   );

   pwmfg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tick   (tick),
      .period (per_q),
      .rep_sel(rep_q),
      .cnt    (cnt_q),
      .cnt_nxt(cnt_nxt),
      .wrap   (wrap),
      .win_end(win_end)
   );

   pwmfg_fifo #(.WIDTH(CNT_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (swr_q),
      .push (push_req),
      .pop  (pop),
      .din  (bus_wdata[CNT_W-1:0]),
      .dout (head),
      .level(fifo_level),
      .full (fifo_full),
      .empty(fifo_empty)
   );

   pwmfg_wave #(.CNT_W(CNT_W)) u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (swr_q),
      .run    (run),
      .tick   (tick),
      .avail  (!fifo_empty),
      .head   (head),
      .win_end(win_end),
      .cnt    (cnt_q),
      .cnt_nxt(cnt_nxt),
      .period (per_q),
      .pol_low(pol_low),
      .pop    (pop),
      .cur    (cur),
      .cmp_ev (cmp_ev),
      .pwm_out(pwm_out)
   );

   // control, enable and period registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         swr_q <= 1'b0;
         rep_q <= '0;
         pol_q <= '0;
         div_q <= '0;
         ie_q  <= '0;
         per_q <= '0;
      end else begin
         if (wr_ctrl) begin
            en_q  <= bus_wdata[C_EN];
            rep_q <= bus_wdata[C_REP_LO +: 2];
            div_q <= bus_wdata[C_DIV_LO +: DIV_W];
            pol_q <= bus_wdata[C_POL_LO +: 2];
            swr_q <= bus_wdata[C_SWR];
         end else begin
            swr_q <= 1'b0;
         end
         if (wr_ien) ie_q  <= bus_wdata[2:0];
         if (wr_per) per_q <= bus_wdata[CNT_W-1:0];
      end
   end

   // event flags: set wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwe_q <= 1'b0;
         cmp_q <= 1'b0;
         rov_q <= 1'b0;
      end else if (swr_q) begin
         fwe_q <= 1'b0;
         cmp_q <= 1'b0;
         rov_q <= 1'b0;
      end else begin
         fwe_q <= (fwe_q && !(wr_stat && bus_wdata[S_FWE])) || fwe_set;
         cmp_q <= (cmp_q && !(wr_stat && bus_wdata[S_CMP])) || cmp_ev;
         rov_q <= (rov_q && !(wr_stat && bus_wdata[S_ROV])) || wrap;
      end
   end

   // interrupt fan-in
   logic [2:0] irq_src;
   assign irq_src[I_CMP]   = cmp_q;
   assign irq_src[I_ROV]   = rov_q;
   assign irq_src[I_EMPTY] = fifo_empty;
   assign irq = |(irq_src & ie_q);

   // read multiplexer
   always_comb begin
      bus_rdata = '0;
      case (bus_addr)
         ADDR_W'(REG_CTRL): begin
            bus_rdata[C_EN]               = en_q;
            bus_rdata[C_REP_LO +: 2]      = rep_q;
            bus_rdata[C_SWR]              = swr_q;
            bus_rdata[C_DIV_LO +: DIV_W]  = div_q;
            bus_rdata[C_POL_LO +: 2]      = pol_q;
         end
         ADDR_W'(REG_STAT): begin
            bus_rdata[S_FWE]       = fwe_q;
            bus_rdata[S_CMP]       = cmp_q;
            bus_rdata[S_ROV]       = rov_q;
            bus_rdata[S_EMPTY]     = fifo_empty;
            bus_rdata[LVL_W-1:0]   = fifo_level;
         end
         ADDR_W'(REG_IEN):  bus_rdata[2:0]       = ie_q;
         ADDR_W'(REG_SAMP): bus_rdata[CNT_W-1:0] = cur;
         ADDR_W'(REG_PER):  bus_rdata[CNT_W-1:0] = per_q;
         ADDR_W'(REG_CNT):  bus_rdata[CNT_W-1:0] = cnt_q;
         default:           bus_rdata = '0;
      endcase
   end

   // R12: the reset request lasts one cycle and leaves the queue and flags clear
   a_r12_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (swr_q && !wr_ctrl) |=> !swr_q);

   a_r12_flush_state: assert property (@(posedge clk) disable iff (!rst_n)
      swr_q |=> (fifo_level == '0 && !fwe_q && !cmp_q && !rov_q && cnt_q == '0));

   // R10: a flag holds until a write of one or the software reset
   a_r10_rov_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (rov_q && !wr_stat && !swr_q) |=> rov_q);

   // R11: with every enable off the line stays quiet
   a_r11_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q == '0) |-> !irq);

   // R5: an overflow push always raises the write error flag
   a_r5_fwe_raise: assert property (@(posedge clk) disable iff (!rst_n)
      fwe_set |=> fwe_q);

endmodule

// File: tb/sim_pwm_fifo_gen.sv
module sim_pwm_fifo_gen;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        pwm_out;
   logic        irq;

   always #5 clk = ~clk;

   pwm_fifo_gen u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .bus_wr   (bus_wr),
      .bus_addr (bus_addr),
      .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata),
      .pwm_out  (pwm_out),
      .irq      (irq)
   );

   int    n_chk = 0;
   int    n_err = 0;
   bit    done = 0;
   string tag = "R1";

   // behavioural reference state
   int m_en, m_rep, m_swr, m_div, m_pol, m_ie, m_per;
   int m_pre, m_cnt, m_repc, m_cur, m_valid, m_fwe, m_cmp, m_rov;
   int q[$];

   task automatic chk(input bit ok, input string what, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(posedge clk) begin : model
      int run, tick, wrap, cn, cmp, winend, fetch, oldsz, push, d, a, w1c;
      if (!rst_n) begin
         m_en = 0; m_rep = 0; m_swr = 0; m_div = 0; m_pol = 0; m_ie = 0; m_per = 0;
         m_pre = 0; m_cnt = 0; m_repc = 0; m_cur = 0; m_valid = 0;
         m_fwe = 0; m_cmp = 0; m_rov = 0;
         q.delete();
      end else begin
         d = int'(bus_wdata);
         a = int'(bus_addr);
         run    = (m_en != 0 && m_swr == 0) ? 1 : 0;
         tick   = (run != 0 && m_pre >= m_div) ? 1 : 0;
         wrap   = (tick != 0 && m_cnt >= m_per) ? 1 : 0;
         cn     = (wrap != 0) ? 0 : m_cnt + 1;
         cmp    = (tick != 0 && m_valid != 0 && cn == m_cur) ? 1 : 0;
         winend = (wrap != 0 && m_repc >= (1 << m_rep) - 1) ? 1 : 0;
         oldsz  = q.size();
         fetch  = (run != 0 && oldsz > 0 && (m_valid == 0 || winend != 0)) ? 1 : 0;
         push   = (bus_wr && a == 3 && m_swr == 0) ? 1 : 0;
         w1c    = (bus_wr && a == 1) ? d : 0;
         if (m_swr != 0) begin
            q.delete();
            m_pre = 0; m_cnt = 0; m_repc = 0; m_cur = 0; m_valid = 0;
            m_fwe = 0; m_cmp = 0; m_rov = 0;
         end else begin
            m_pre  = (run == 0 || tick != 0) ? 0 : m_pre + 1;
            m_cnt  = (run == 0) ? 0 : (tick != 0) ? cn : m_cnt;
            m_repc = (run == 0) ? 0 : (wrap != 0) ? ((winend != 0) ? 0 : m_repc + 1) : m_repc;
            if (fetch != 0) begin
               m_cur = q.pop_front();
               m_valid = 1;
            end
            m_fwe = ((m_fwe != 0 && ((w1c >> 6) & 1) == 0) || (push != 0 && oldsz >= DEPTH)) ? 1 : 0;
            m_cmp = ((m_cmp != 0 && ((w1c >> 5) & 1) == 0) || cmp != 0) ? 1 : 0;
            m_rov = ((m_rov != 0 && ((w1c >> 4) & 1) == 0) || wrap != 0) ? 1 : 0;
            if (push != 0 && oldsz < DEPTH) q.push_back(d & 32'hFFFF);
         end
         m_swr = 0;
         if (bus_wr && a == 0) begin
            m_en  = d & 1;
            m_rep = (d >> 1) & 3;
            m_swr = (d >> 3) & 1;
            m_div = (d >> 4) & 32'hFFF;
            m_pol = (d >> 18) & 3;
         end
         if (bus_wr && a == 2) m_ie  = d & 7;
         if (bus_wr && a == 4) m_per = d & 32'hFFFF;
      end
   end

   function automatic int exp_rd(input int a);
      case (a)
         0: return m_en | (m_rep << 1) | (m_swr << 3) | (m_div << 4) | (m_pol << 18);
         1: return (m_fwe << 6) | (m_cmp << 5) | (m_rov << 4) |
                   (int'(q.size() == 0) << 3) | q.size();
         2: return m_ie;
         3: return m_cur;
         4: return m_per;
         5: return m_cnt;
         default: return 0;
      endcase
   endfunction

   function automatic int exp_out();
      int act;
      act = (m_en != 0 && m_swr == 0 && m_valid != 0 && m_cur != 0 &&
             (m_cnt < m_cur || m_cur >= m_per)) ? 1 : 0;
      return act ^ ((m_pol == 1) ? 1 : 0);
   endfunction

   function automatic int exp_irq();
      return ((m_cmp & (m_ie >> 2)) | (m_rov & (m_ie >> 1)) |
              (int'(q.size() == 0) & m_ie)) & 1;
   endfunction

   // cycle-by-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(int'(pwm_out) == exp_out(), "pwm_out", longint'(pwm_out), longint'(exp_out()));
         chk(int'(irq) == exp_irq(), "irq", longint'(irq), longint'(exp_irq()));
         chk(int'(bus_rdata) == exp_rd(int'(bus_addr)), "rdata",
             longint'(bus_rdata), longint'(exp_rd(int'(bus_addr))));
      end
   end

   task automatic wr(input int a, input int d);
      @(posedge clk); #2;
      bus_wr = 1'b1;
      bus_addr = 3'(a);
      bus_wdata = 32'(d);
      @(posedge clk); #2;
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n, input int a);
      @(posedge clk); #2;
      bus_addr = 3'(a);
      repeat (n) @(posedge clk);
   endtask

   task automatic expect_rd(input int a, input int exp, input string what);
      @(posedge clk); #2;
      bus_addr = 3'(a);
      @(negedge clk);
      chk(int'(bus_rdata) == exp, what, longint'(bus_rdata), longint'(exp));
   endtask

   task automatic finish_up();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         finish_up();
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;

      // R1 reset state
      tag = "R1";
      bus_addr = 3'd1;
      @(negedge clk);
      chk(pwm_out == 1'b0, "R1 out after reset", longint'(pwm_out), 0);
      chk(irq == 1'b0, "R1 irq after reset", longint'(irq), 0);
      chk(bus_rdata == 32'h8, "R1 status after reset", longint'(bus_rdata), 8);
      expect_rd(5, 0, "R1 counter after reset");
      expect_rd(3, 0, "R1 sample after reset");

      // R2 register map read back
      tag = "R2";
      wr(0, 32'h0004_0016);
      expect_rd(0, 32'h0004_0016, "R2 control readback");
      wr(4, 9);
      expect_rd(4, 9, "R2 period readback");
      wr(2, 5);
      expect_rd(2, 5, "R2 enable readback");
      expect_rd(6, 0, "R2 unused index");
      wr(0, 0);

      // R5 queue fill and overflow
      tag = "R5";
      wr(3, 3); wr(3, 7); wr(3, 0); wr(3, 12);
      expect_rd(1, 32'h04, "R5 level four");
      wr(3, 5);
      expect_rd(1, 32'h44, "R5 overflow flag");

      // R10 write-one-to-clear
      tag = "R10";
      wr(1, 0);
      expect_rd(1, 32'h44, "R10 zero write keeps flag");
      wr(1, 32'h40);
      expect_rd(1, 32'h04, "R10 one write clears flag");

      // R6 first fetch and single-period windows
      tag = "R6";
      wr(0, 32'h11);
      expect_rd(3, 3, "R6 first sample taken");
      idle(120, 3);

      // R4 counter profile
      tag = "R4";
      idle(60, 5);

      // R7 zero, equal-to-period and mid samples
      tag = "R7";
      wr(3, 0); wr(3, 9); wr(3, 4);
      idle(100, 3);

      // R6 four-period windows
      tag = "R6";
      wr(0, 32'h15);
      wr(3, 2); wr(3, 6);
      idle(200, 3);

      // R8 active-low
      tag = "R8";
      wr(3, 5);
      wr(0, 32'h0004_0015);
      idle(100, 0);

      // R9 event flags with interrupts masked
      tag = "R9";
      wr(2, 0);
      wr(0, 32'h11);
      wr(3, 4);
      idle(60, 1);

      // R11 interrupt fan-in
      tag = "R11";
      wr(2, 7);
      idle(30, 1);
      wr(1, 32'h70);
      idle(30, 1);
      wr(2, 2);
      idle(30, 1);

      // R10 clears racing with new events
      tag = "R10";
      repeat (6) begin
         wr(1, 32'h30);
         idle(3, 1);
      end

      // R3 other divide ratios and disable
      tag = "R3";
      wr(0, 32'h31);
      idle(100, 5);
      wr(0, 32'h01);
      idle(30, 5);
      wr(0, 0);
      expect_rd(5, 0, "R3 counter cleared on disable");
      idle(10, 5);

      // R12 software reset
      tag = "R12";
      wr(0, 32'h11);
      wr(3, 6); wr(3, 8);
      idle(40, 1);
      wr(0, 32'h19);
      expect_rd(1, 32'h08, "R12 status after software reset");
      expect_rd(0, 32'h11, "R12 control after software reset");
      expect_rd(3, 0, "R12 sample after software reset");
      wr(3, 3);
      idle(40, 3);

      finish_up();
   end

endmodule